// File: doc/BRIEF.md
# Multi-Mode Serial Transmitter

This block turns one byte at a time into a serial bit stream on a single data line. It has three framing modes: plain asynchronous (start bit, data, optional parity, stop bits), asynchronous multiprocessor (start bit, data, an address/data flag bit, stop bits) and clock-synchronous (eight data bits only, with a shift clock). An 8-bit control register selects the mode and the frame options. The same register also sets whether the shift clock pin is driven by the block and whether the data pin carries the serial stream or a plain general-purpose level.

Bytes enter through a valid/ready handshake. `tx_ready` is high exactly when the engine is idle. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. While a frame is in flight, `tx_ready` stays low, and a producer that holds `tx_valid` high simply waits. Nothing is queued and nothing is dropped silently. The mode, the clock source and the whole bit pattern are fixed when the byte is taken. Later register writes only affect the pin routing and the next frame.

Bit timing comes from one of two places. The first is a one-cycle `baud_tick` pulse from an external rate generator. The second is edges on `sck_in`, which pass through a two-flop synchronizer plus an edge-detect flop, so an edge takes effect on the third clock after it appears.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset, the control register reads 0x04 and `tx_busy` is 0. `tx_ready` is 1, `sck_oe` is 0, `sck_out` is 1, and `sdo` equals `gpo_val`.
- R2: Control byte layout: bit 7 enables parity, bit 6 selects odd parity (0 = even), and bit 5 selects two stop bits. Bits 4:3 hold the mode (0 async, 1 multiprocessor, 2 synchronous, 3 treated as 0). Bit 2 selects `baud_tick` timing (1) or `sck_in` rising edges (0) for async modes. Bit 1 drives the clock in synchronous mode, and bit 0 routes serial data to `sdo`. An async frame is a low start bit, then 8 data bits LSB first, then the stop bits as high. Each bit holds until the next timing event, and the idle line is high.
- R3: In mode 0 with parity enabled, one parity bit follows the data. For even parity it makes the count of ones over data plus parity even; for odd parity it makes that count odd.
- R4: In modes 1 and 2 no parity bit is sent, whatever bit 7 holds. In mode 1 the `tx_flag` value captured with the byte is sent after the data bits.
- R5: In mode 2 with bit 1 set, only the 8 data bits go out, LSB first, with no start or stop bit. Each `baud_tick` toggles `sck_out`, and data changes only on falling edges after the first. Each bit is stable across the rising edge that follows. `sck_out` rests high whenever the engine is idle.
- R6: `sck_oe` is 1 only when the mode is 2 and bit 1 is set. In every other setting it is 0.
- R7: With bit 0 clear, `sdo` follows `gpo_val` at all times, even while a frame is being shifted.
- R8: A byte is accepted only when `tx_valid` and `tx_ready` are both high. `tx_busy` is then high from the next cycle until the timing event that ends the last bit. A `tx_valid` held high during a frame starts nothing and does not disturb it.
- R9: In modes 0 and 1 with bit 2 clear, bits advance on rising edges of `sck_in`, and `baud_tick` has no effect.
- R10: In mode 2 with bit 1 clear, the block does not drive the clock. Bits shift on falling edges of `sck_in` after the first, and the frame ends on the rising edge after the eighth bit. `baud_tick` is ignored.
- R11: A register write in the same cycle as an accepted byte takes effect on the register, but that frame uses the previous settings. A write during a frame does not change the frame's length or content.
- R12: Mode 3 produces exactly the frames of mode 0, including parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register contents |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Engine idle, byte can be taken |
| tx_data | input | DATA_W | Byte to send |
| tx_flag | input | 1 | Address/data flag sent in mode 1 |
| baud_tick | input | 1 | One-cycle bit-rate pulse |
| gpo_val | input | 1 | General-purpose level for `sdo` |
| sck_in | input | 1 | External shift clock / timing input |
| sck_out | output | 1 | Shift clock driven by the block |
| sck_oe | output | 1 | Enable for the shift clock pin driver |
| sdo | output | 1 | Serial data or general-purpose level |
| tx_busy | output | 1 | Frame in progress |

## Verification
A register write and a byte acceptance can land on the same clock edge. This case decides whether the frame picks up the old settings or the new ones. The bench provokes it by raising `cfg_we` and `tx_valid` in one cycle, with a write that would add parity and a second stop bit. It then counts the bits and the timing events up to the fall of `tx_busy`, and the result must match the frame built from the earlier settings. A further write lands mid-frame, and the bench checks that the remaining bits and the frame length stay as they were.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_MPROC = 2'd1,
    MODE_SYNC  = 2'd2,
    MODE_ALT   = 2'd3
  } sertx_mode_e;

  // Control byte, MSB first: bit 7 .. bit 0
  typedef struct packed {
    logic        par_en;
    logic        par_odd;
    logic        stop2;
    sertx_mode_e mode;
    logic        tick_int;
    logic        sck_drive;
    logic        sdo_serial;
  } sertx_cfg_t;

  localparam logic [7:0] CFG_RESET = 8'h04;

  // Frame context captured when a byte is taken
  typedef struct packed {
    logic sync;
    logic drive;
    logic tick_int;
  } sertx_ctx_t;

endpackage

// File: rtl/sertx_cfg_reg.sv
module sertx_cfg_reg
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output sertx_cfg_t cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= sertx_cfg_t'(CFG_RESET);
    end else if (we) begin
      cfg <= sertx_cfg_t'(wdata);
    end
  end

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  sertx_cfg_t         cfg,
  input  logic [DATA_W-1:0]  data,
  input  logic               flag,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);

  logic has_x;
  logic xbit;

  always_comb begin
    frame = '1;
    nbits = '0;
    has_x = 1'b0;
    xbit  = 1'b0;
    if (cfg.mode == MODE_SYNC) begin
      frame[DATA_W-1:0] = data;
      nbits = CNT_W'(DATA_W);
    end else begin
      frame[0]        = 1'b0;
      frame[DATA_W:1] = data;
      if (cfg.mode == MODE_MPROC) begin
        has_x = 1'b1;
        xbit  = flag;
      end else if (cfg.par_en) begin
        has_x = 1'b1;
        xbit  = (^data) ^ cfg.par_odd;
      end
      if (has_x) begin
        frame[DATA_W+1] = xbit;
      end
      nbits = CNT_W'(DATA_W + 2) + CNT_W'(has_x) + CNT_W'(cfg.stop2);
    end
  end

endmodule

// File: rtl/sertx_clk_evt.sv
module sertx_clk_evt
  import sertx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       sck_in,
  input  logic       busy,
  input  sertx_ctx_t ctx,
  output logic       evt_bit,
  output logic       evt_fall,
  output logic       evt_rise,
  output logic       sck_out
);

  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] sck_chain;
  logic             sck_q;
  logic             ext_rise;
  logic             ext_fall;

  genvar g;
  generate
    for (g = 0; g < CHAIN; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sck_chain[g] <= 1'b0;
          else        sck_chain[g] <= sck_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sck_chain[g] <= 1'b0;
          else        sck_chain[g] <= sck_chain[g-1];
        end
      end
    end
  endgenerate

  assign ext_rise =  sck_chain[CHAIN-2] & ~sck_chain[CHAIN-1];
  assign ext_fall = ~sck_chain[CHAIN-2] &  sck_chain[CHAIN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b1;
    end else if (!busy) begin
      sck_q <= 1'b1;
    end else if (ctx.sync && ctx.drive && baud_tick) begin
      sck_q <= ~sck_q;
    end
  end

  assign evt_bit  = !ctx.sync && (ctx.tick_int ? baud_tick : ext_rise);
  assign evt_fall =  ctx.sync && (ctx.drive ? (baud_tick &&  sck_q) : ext_fall);
  assign evt_rise =  ctx.sync && (ctx.drive ? (baud_tick && !sck_q) : ext_rise);
  assign sck_out  = sck_q;

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [CNT_W-1:0]   nbits,
  input  sertx_ctx_t         ctx_in,
  input  logic               evt_bit,
  input  logic               evt_fall,
  input  logic               evt_rise,
  output logic               busy,
  output logic               ser_bit,
  output sertx_ctx_t         ctx
);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cnt;
  logic               first;
  logic               last;

  assign last = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '1;
      cnt   <= '0;
      busy  <= 1'b0;
      first <= 1'b0;
      ctx   <= '0;
    end else if (load) begin
      sh    <= frame;
      cnt   <= nbits;
      busy  <= 1'b1;
      first <= 1'b1;
      ctx   <= ctx_in;
    end else if (busy) begin
      if (evt_bit) begin
        if (last) begin
          busy <= 1'b0;
        end else begin
          sh  <= {1'b1, sh[FRAME_W-1:1]};
          cnt <= cnt - CNT_W'(1);
        end
      end
      if (evt_fall) begin
        first <= 1'b0;
        if (!first) begin
          sh  <= {1'b1, sh[FRAME_W-1:1]};
          cnt <= cnt - CNT_W'(1);
        end
      end
      if (evt_rise && !first && last) begin
        busy <= 1'b0;
      end
    end
  end

  assign ser_bit = busy ? sh[0] : 1'b1;

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import sertx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_flag,
  input  logic              baud_tick,
  input  logic              gpo_val,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  output logic              sdo,
  output logic              tx_busy
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  sertx_cfg_t         cfg;
  sertx_ctx_t         ctx_in;
  sertx_ctx_t         ctx;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;
  logic               busy;
  logic               ser_bit;
  logic               accept;
  logic               evt_bit;
  logic               evt_fall;
  logic               evt_rise;

  sertx_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  sertx_framer #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_framer (
    .cfg   (cfg),
    .data  (tx_data),
    .flag  (tx_flag),
    .frame (frame),
    .nbits (nbits)
  );

  assign ctx_in.sync     = (cfg.mode == MODE_SYNC);
  assign ctx_in.drive    = cfg.sck_drive;
  assign ctx_in.tick_int = cfg.tick_int;

  assign accept = tx_valid && !busy;

  sertx_shifter #(
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .frame    (frame),
    .nbits    (nbits),
    .ctx_in   (ctx_in),
    .evt_bit  (evt_bit),
    .evt_fall (evt_fall),
    .evt_rise (evt_rise),
    .busy     (busy),
    .ser_bit  (ser_bit),
    .ctx      (ctx)
  );

  sertx_clk_evt #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .sck_in    (sck_in),
    .busy      (busy),
    .ctx       (ctx),
    .evt_bit   (evt_bit),
    .evt_fall  (evt_fall),
    .evt_rise  (evt_rise),
    .sck_out   (sck_out)
  );

  assign cfg_rdata = cfg;
  assign sdo       = cfg.sdo_serial ? ser_bit : gpo_val;
  assign sck_oe    = (cfg.mode == MODE_SYNC) && cfg.sck_drive;
  assign tx_busy   = busy;
  assign tx_ready  = !busy;

endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic [7:0] cfg_rdata,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       gpo_val,
  input logic       sck_out,
  input logic       sck_oe,
  input logic       sdo,
  input logic       tx_busy
);

  p_reset_cfg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && !$past(cfg_we)) |-> (cfg_rdata == 8'h04));

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && cfg_rdata[0]) |-> sdo);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !cfg_we && cfg_rdata[0] && cfg_rdata[4:3] != 2'd2)
    |=> !sdo);

  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> sck_out);

  p_sck_oe_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[4:3] != 2'd2) |-> !sck_oe);

  p_gpo_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[0] |-> (sdo == gpo_val));

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (tx_busy && !tx_ready));

endmodule

bind serial_tx_engine sertx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .gpo_val   (gpo_val),
  .sck_out   (sck_out),
  .sck_oe    (sck_oe),
  .sdo       (sdo),
  .tx_busy   (tx_busy)
);

// File: tb/serial_tx_engine_tb.sv
module serial_tx_engine_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       tx_flag = 1'b0;
  logic       baud_tick = 1'b0;
  logic       gpo_val = 1'b0;
  logic       sck_in = 1'b1;
  logic       sck_out;
  logic       sck_oe;
  logic       sdo;
  logic       tx_busy;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  serial_tx_engine u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_flag   (tx_flag),
    .baud_tick (baud_tick),
    .gpo_val   (gpo_val),
    .sck_in    (sck_in),
    .sck_out   (sck_out),
    .sck_oe    (sck_oe),
    .sdo       (sdo),
    .tx_busy   (tx_busy)
  );

  // {cfg, data, flag}; all with bit 2 (tick) and bit 0 (serial) set
  localparam logic [16:0] VECS [8] = '{
    {8'h05, 8'hA5, 1'b0},  // R2 mode 0, no parity, one stop
    {8'h85, 8'h07, 1'b0},  // R3 even parity
    {8'hC5, 8'h07, 1'b0},  // R3 odd parity
    {8'hE5, 8'h00, 1'b0},  // R3 odd parity, two stops
    {8'h25, 8'hFF, 1'b0},  // R2 two stops
    {8'h8D, 8'h3C, 1'b1},  // R4 mode 1, parity bit ignored, flag 1
    {8'h0D, 8'h81, 1'b0},  // R4 mode 1, flag 0
    {8'h9D, 8'h01, 1'b0}   // R12 mode 3 with even parity
  };

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic chk8(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_we = 1'b1;
    cfg_wdata = v;
    cyc(1);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic f);
    tx_valid = 1'b1;
    tx_data = d;
    tx_flag = f;
    cyc(1);
    tx_valid = 1'b0;
  endtask

  task automatic tick();
    baud_tick = 1'b1;
    cyc(1);
    baud_tick = 1'b0;
  endtask

  task automatic sck_to(input logic v);
    sck_in = v;
    cyc(4);
  endtask

  // Expected async frame from the control byte (R2, R3, R4, R12)
  task automatic mk_frame(input logic [7:0] c, input logic [7:0] d, input logic f,
                          output logic [11:0] b, output int n);
    logic [1:0] m;
    m = c[4:3];
    b = '1;
    b[0] = 1'b0;
    for (int k = 0; k < 8; k++) b[k+1] = d[k];
    n = 9;
    if (m == 2'd1) begin
      b[n] = f;
      n++;
    end else if (c[7]) begin
      b[n] = c[6] ? ~(^d) : (^d);
      n++;
    end
    n += c[5] ? 2 : 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R8 watchdog: got hung run expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] b;
    int          n;

    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    chk8("R1", "cfg_rdata", cfg_rdata, 8'h04);
    chk("R1", "tx_busy", tx_busy, 1'b0);
    chk("R1", "tx_ready", tx_ready, 1'b1);
    chk("R1", "sck_oe", sck_oe, 1'b0);
    chk("R1", "sck_out", sck_out, 1'b1);
    chk("R1", "sdo=gpo 0", sdo, 1'b0);
    gpo_val = 1'b1;
    cyc(1);
    chk("R1", "sdo=gpo 1", sdo, 1'b1);
    gpo_val = 1'b0;

    // Vector table: async framings
    for (int v = 0; v < 8; v++) begin
      logic [7:0] c;
      logic [7:0] d;
      logic       f;
      string      tag;
      c = VECS[v][16:9];
      d = VECS[v][8:1];
      f = VECS[v][0];
      if (c[4:3] == 2'd1)      tag = "R4";
      else if (c[4:3] == 2'd3) tag = "R12";
      else if (c[7])           tag = "R3";
      else                     tag = "R2";
      mk_frame(c, d, f, b, n);
      wr_cfg(c);
      chk("R6", "sck_oe async", sck_oe, 1'b0);
      send(d, f);
      for (int k = 0; k < n; k++) begin
        chk(tag, $sformatf("vec %0d bit %0d", v, k), sdo, b[k]);
        chk("R8", "busy in frame", tx_busy, 1'b1);
        tick();
      end
      chk("R8", $sformatf("vec %0d busy end", v), tx_busy, 1'b0);
      chk("R2", "idle high", sdo, 1'b1);
    end

    // R8: valid held while busy is not taken
    wr_cfg(8'h05);
    mk_frame(8'h05, 8'h0F, 1'b0, b, n);
    send(8'h0F, 1'b0);
    tx_valid = 1'b1;
    tx_data = 8'hF0;
    for (int k = 0; k < n; k++) begin
      chk("R8", $sformatf("held valid bit %0d", k), sdo, b[k]);
      chk("R8", "ready low", tx_ready, 1'b0);
      if (k == n - 1) tx_valid = 1'b0;
      tick();
    end
    chk("R8", "busy end", tx_busy, 1'b0);
    tick();
    chk("R8", "no second frame", tx_busy, 1'b0);
    chk("R8", "line idle", sdo, 1'b1);

    // R7: general-purpose routing while shifting
    wr_cfg(8'h04);
    gpo_val = 1'b1;
    send(8'h00, 1'b0);
    chk("R7", "sdo gpo 1 while busy", sdo, 1'b1);
    chk("R7", "busy", tx_busy, 1'b1);
    tick();
    gpo_val = 1'b0;
    cyc(1);
    chk("R7", "sdo gpo 0 while busy", sdo, 1'b0);
    repeat (9) tick();
    chk("R7", "frame done", tx_busy, 1'b0);

    // R11: write and accept in the same cycle, then a write mid-frame
    wr_cfg(8'h05);
    mk_frame(8'h05, 8'h01, 1'b0, b, n);
    tx_valid = 1'b1;
    tx_data = 8'h01;
    cfg_we = 1'b1;
    cfg_wdata = 8'hA5;
    cyc(1);
    tx_valid = 1'b0;
    cfg_we = 1'b0;
    chk8("R11", "register took write", cfg_rdata, 8'hA5);
    for (int k = 0; k < n; k++) begin
      if (k == 4) wr_cfg(8'h45);
      chk("R11", $sformatf("old-settings bit %0d", k), sdo, b[k]);
      chk("R11", "busy", tx_busy, 1'b1);
      tick();
    end
    chk("R11", "length from old settings", tx_busy, 1'b0);

    // R5 / R4: synchronous, clock driven, parity bit set but ignored
    wr_cfg(8'h97);
    chk("R6", "sck_oe sync drive", sck_oe, 1'b1);
    send(8'h6B, 1'b0);
    chk("R5", "first bit no start", sdo, 1'b1);
    chk("R5", "sck rest high", sck_out, 1'b1);
    for (int k = 0; k < 8; k++) begin
      tick();
      chk("R5", $sformatf("sck low %0d", k), sck_out, 1'b0);
      chk("R5", $sformatf("data at fall %0d", k), sdo, 8'h6B >> k);
      tick();
      chk("R5", $sformatf("sck high %0d", k), sck_out, 1'b1);
      if (k < 7) chk("R5", $sformatf("data at rise %0d", k), sdo, 8'h6B >> k);
      chk("R4", $sformatf("busy after rise %0d", k), tx_busy, k < 7);
    end
    tick();
    chk("R5", "sck stays high idle", sck_out, 1'b1);
    chk("R4", "no parity bit", tx_busy, 1'b0);

    // R10: synchronous, external clock
    wr_cfg(8'h11);
    chk("R6", "sck_oe sync ext", sck_oe, 1'b0);
    sck_in = 1'b1;
    cyc(4);
    send(8'hC4, 1'b0);
    tick();
    chk("R10", "tick ignored", sdo, 1'b0);
    chk("R10", "no clock toggling", sck_out, 1'b1);
    for (int k = 0; k < 8; k++) begin
      sck_to(1'b0);
      chk("R10", $sformatf("ext bit %0d", k), sdo, 8'hC4 >> k);
      sck_to(1'b1);
      if (k < 7) chk("R10", $sformatf("ext hold %0d", k), sdo, 8'hC4 >> k);
      chk("R10", $sformatf("busy %0d", k), tx_busy, k < 7);
    end

    // R9: async timed by sck_in rising edges
    sck_in = 1'b0;
    cyc(4);
    wr_cfg(8'h01);
    mk_frame(8'h01, 8'h5A, 1'b0, b, n);
    send(8'h5A, 1'b0);
    tick();
    chk("R9", "baud tick ignored", sdo, 1'b0);
    for (int k = 0; k < n; k++) begin
      chk("R9", $sformatf("edge bit %0d", k), sdo, b[k]);
      sck_to(1'b1);
      sck_to(1'b0);
    end
    chk("R9", "busy end", tx_busy, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule